// File: doc/BRIEF.md
# Rijndael 256-bit Block Encryption Engine

This block encrypts one 256-bit data block under a 256-bit key with the Rijndael cipher in its wide-block form. Both the block and the key are eight 32-bit columns of four bytes. The engine is encrypt-only. It is iterative: it works through one cipher round per clock cycle and derives every round key from the one before it while it runs, so it stores no expanded key schedule.

A client presents a key and a plaintext and raises `start` for one cycle. The engine registers both operands on that edge. Fourteen cycles later it has run all fourteen round transformations, and one more cycle applies the closing key addition. The result then appears on `cipherOut`, and `done` pulses for one cycle. The result stays on `cipherOut` until the next operation completes. The engine takes no new request while it is working.

Top module: `rijn256_enc`

## Requirements
- R1: After reset `done` is low and `cipherOut` is all zero. A reset in the middle of an operation abandons it, so that no `done` follows.
- R2: In `keyIn`, `plainIn` and `cipherOut`, byte b (0..31) is column b/4, row b%4, and sits at bits [255-8b -: 8]. Byte 0 is the most significant byte.
- R3: When `start` is sampled high at an idle clock edge, `done` is high for exactly one cycle, during the cycle that follows the 15th clock edge after that edge.
- R4: `cipherOut` is the Rijndael encryption with a 256-bit block, a 256-bit key and 14 rounds. The steps are an initial key addition, thirteen rounds of byte substitution, row shift, column mix and key addition, then a last round that has no column mix.
- R5: The round steps use the standard Rijndael S-box (0x00 maps to 0x63, 0x01 maps to 0x7C). Rows 0, 1, 2 and 3 rotate left by 0, 1, 3 and 4 columns, modulo 8. The column mix gives out_i = s_i ^ (s0^s1^s2^s3) ^ xtime(s_i ^ s_(i+1 mod 4)), where xtime reduces with 0x1B.
- R6: Each round key comes from the previous one. A temporary word is made from the last column: rotated up by one byte, passed through the S-box, and XORed with the round constant in its first byte. That word is folded cumulatively into columns 0 to 3. Column 3 of the new key then passes through the S-box with no rotation and no constant before it is folded into columns 4 to 7. The round constant starts at 0x01 and is doubled in GF(2^8) with 0x1B after each use.
- R7: Key and plaintext are captured on the accepting edge. Later changes on `keyIn` and `plainIn` do not change the result.
- R8: A `start` that arrives while an operation runs is ignored. The running operation keeps its timing and its result, and no extra `done` follows.
- R9: `cipherOut` holds its value between completions, whatever happens on the inputs.
- R10: A `start` given in the cycle in which `done` is high is accepted, and it produces its own result 15 edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request pulse; accepted only when idle |
| keyIn | input | 256 | Cipher key, byte 0 in the MSBs |
| plainIn | input | 256 | Plaintext block, byte 0 in the MSBs |
| done | output | 1 | One-cycle completion pulse |
| cipherOut | output | 256 | Ciphertext of the last completed operation |

## Verification
The bench builds the engine with its default round count of fourteen. The cipher, its key schedule and its round-constant sequence are only defined for that value. With this setting the bench reaches every round-constant value, including the ones where doubling overflows and reduction with 0x1B applies. It also reaches the extra S-box pass at key column 4 in every key step. The bench compares each result with an independent reference model that expands the whole key schedule up front, and it checks the operand capture, busy-ignore, back-to-back and mid-run reset cases on their exact cycles.

// File: rtl/rijn_pkg.sv
package rijn_pkg;

  localparam int COLS   = 8;
  localparam int ROWS   = 4;
  localparam int BYTE_W = 8;
  localparam int COL_W  = ROWS * BYTE_W;
  localparam int BLK_W  = COLS * COL_W;
  localparam int ROUNDS = 14;

  typedef struct packed {
    logic load;       // capture operands
    logic step;       // perform one round and one key step
    logic firstPass;  // skip column mixing on this round
    logic finish;     // closing key addition into the output register
  } ctrlStrobes_t;

  // left rotation, in columns, applied to each row
  function automatic int rowShift(input int r);
    case (r)
      0:       return 0;
      1:       return 1;
      2:       return 3;
      default: return 4;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] byteAt(input logic [BLK_W-1:0] v, input int idx);
    return v[BLK_W-1-BYTE_W*idx -: BYTE_W];
  endfunction

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = xtime(sh);
    end
    return acc;
  endfunction

  // multiplicative inverse as x^254, then the affine map
  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] p2, p3, p6, p12, p15, p30, p60, p120, p240, inv;
    p2   = gfMul(x, x);
    p3   = gfMul(p2, x);
    p6   = gfMul(p3, p3);
    p12  = gfMul(p6, p6);
    p15  = gfMul(p12, p3);
    p30  = gfMul(p15, p15);
    p60  = gfMul(p30, p30);
    p120 = gfMul(p60, p60);
    p240 = gfMul(p120, p120);
    inv  = gfMul(gfMul(p240, p12), p2);
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^
           {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [COL_W-1:0] subWord(input logic [COL_W-1:0] w);
    logic [COL_W-1:0] r;
    for (int i = 0; i < ROWS; i++) r[COL_W-1-BYTE_W*i -: BYTE_W] = sbox(w[COL_W-1-BYTE_W*i -: BYTE_W]);
    return r;
  endfunction

endpackage

// File: rtl/rijn_round.sv
module rijn_round
  import rijn_pkg::*;
(
  input  logic [BLK_W-1:0] stateIn,
  input  logic [BLK_W-1:0] roundKey,
  input  logic             skipMix,
  output logic [BLK_W-1:0] stateOut
);

  logic [BYTE_W-1:0] inB  [COLS][ROWS];
  logic [BYTE_W-1:0] mixB [COLS][ROWS];
  logic [BYTE_W-1:0] subB [COLS][ROWS];

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [BYTE_W-1:0] colSum;

    for (genvar r = 0; r < ROWS; r++) begin : g_in
      assign inB[c][r] = byteAt(stateIn, c*ROWS + r);
    end

    assign colSum = inB[c][0] ^ inB[c][1] ^ inB[c][2] ^ inB[c][3];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
      localparam int NXT = (r + 1) % ROWS;
      localparam int SRC = (c + rowShift(r)) % COLS;
      localparam int HI  = BLK_W - 1 - BYTE_W*(c*ROWS + r);

      assign mixB[c][r] = inB[c][r] ^ colSum ^ xtime(inB[c][r] ^ inB[c][NXT]);
      assign subB[c][r] = sbox((skipMix ? inB[c][r] : mixB[c][r]) ^ byteAt(roundKey, c*ROWS + r));
      // R5: row r of output column c is taken from column c + shift(r)
      assign stateOut[HI -: BYTE_W] = subB[SRC][r];
    end
  end

endmodule

// File: rtl/rijn_keystep.sv
module rijn_keystep
  import rijn_pkg::*;
(
  input  logic [BLK_W-1:0]  keyIn,
  input  logic [BYTE_W-1:0] rcon,
  output logic [BLK_W-1:0]  keyOut
);

  localparam int HALF = COLS / 2;

  logic [COL_W-1:0] oldW [COLS];
  logic [COL_W-1:0] newW [COLS];
  logic [COL_W-1:0] lastW;
  logic [COL_W-1:0] headTemp;

  for (genvar i = 0; i < COLS; i++) begin : g_split
    assign oldW[i] = keyIn[BLK_W-1-COL_W*i -: COL_W];
    assign keyOut[BLK_W-1-COL_W*i -: COL_W] = newW[i];
  end

  assign lastW    = oldW[COLS-1];
  assign headTemp = subWord({lastW[COL_W-BYTE_W-1:0], lastW[COL_W-1 -: BYTE_W]}) ^
                    {rcon, {(COL_W-BYTE_W){1'b0}}};

  for (genvar i = 0; i < COLS; i++) begin : g_fold
    if (i == 0) begin : g_head
      assign newW[i] = oldW[i] ^ headTemp;
    end else if (i == HALF) begin : g_mid
      assign newW[i] = oldW[i] ^ subWord(newW[i-1]);   // R6 extra substitution
    end else begin : g_plain
      assign newW[i] = oldW[i] ^ newW[i-1];
    end
  end

endmodule

// File: rtl/rijn_datapath.sv
module rijn_datapath
  import rijn_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [BLK_W-1:0] keyIn,
  input  logic [BLK_W-1:0] plainIn,
  output logic [BLK_W-1:0] cipherOut
);

  logic [BLK_W-1:0]  stateReg;
  logic [BLK_W-1:0]  keyReg;
  logic [BYTE_W-1:0] rconReg;
  logic [BLK_W-1:0]  roundOut;
  logic [BLK_W-1:0]  nextKey;

  rijn_round round_i (
    .stateIn (stateReg),
    .roundKey(keyReg),
    .skipMix (strobes.firstPass),
    .stateOut(roundOut)
  );

  rijn_keystep keystep_i (
    .keyIn (keyReg),
    .rcon  (rconReg),
    .keyOut(nextKey)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateReg  <= '0;
      keyReg    <= '0;
      rconReg   <= '0;
      cipherOut <= '0;
    end else begin
      if (strobes.load) begin
        stateReg <= plainIn;
        keyReg   <= keyIn;
        rconReg  <= 8'h01;
      end else if (strobes.step) begin
        stateReg <= roundOut;
        keyReg   <= nextKey;
        rconReg  <= xtime(rconReg);
      end
      if (strobes.finish) cipherOut <= stateReg ^ keyReg;
    end
  end

  AST_OPERAND_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (stateReg == $past(plainIn)) && (keyReg == $past(keyIn))); // R7
  AST_RCON_SEED: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> rconReg == 8'h01); // R6
  AST_RCON_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |-> rconReg != 8'h00); // R6
  AST_CIPHER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.finish |=> $stable(cipherOut)); // R9

endmodule

// File: rtl/rijn_ctrl.sv
module rijn_ctrl
  import rijn_pkg::*;
#(
  parameter int NUM_ROUNDS = ROUNDS
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output ctrlStrobes_t strobes,
  output logic         done
);

  localparam int CNT_W = $clog2(NUM_ROUNDS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_ROUNDS);

  logic             busy;
  logic [CNT_W-1:0] roundCnt;

  always_comb begin
    strobes.load      = !busy && start;
    strobes.step      = busy && (roundCnt != LAST);
    strobes.firstPass = (roundCnt == '0);
    strobes.finish    = busy && (roundCnt == LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      roundCnt <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (strobes.load) begin
        busy     <= 1'b1;
        roundCnt <= '0;
      end else if (strobes.finish) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else if (strobes.step) begin
        roundCnt <= roundCnt + 1'b1;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R3
  AST_FINISH_SIGNALS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.finish |=> done && !busy); // R3
  AST_BUSY_ADVANCES: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> busy && (roundCnt == CNT_W'($past(roundCnt) + 1'b1))); // R8
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.load, strobes.step, strobes.finish})); // R8

endmodule

// File: rtl/rijn256_enc.sv
module rijn256_enc
  import rijn_pkg::*;
#(
  parameter int NUM_ROUNDS = ROUNDS
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [BLK_W-1:0] keyIn,
  input  logic [BLK_W-1:0] plainIn,
  output logic             done,
  output logic [BLK_W-1:0] cipherOut
);

  ctrlStrobes_t strobes;

  rijn_ctrl #(.NUM_ROUNDS(NUM_ROUNDS)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobes(strobes),
    .done   (done)
  );

  rijn_datapath datapath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .keyIn    (keyIn),
    .plainIn  (plainIn),
    .cipherOut(cipherOut)
  );

endmodule

// File: tb/rijn256_enc_tb_top.sv
`timescale 1ns/100ps
module rijn256_enc_tb_top;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [255:0] keyIn = '0;
  logic [255:0] plainIn = '0;
  logic         done;
  logic [255:0] cipherOut;

  int checks = 0;
  int errors = 0;
  logic [7:0] sbTb [256];

  always #2.5 clk = ~clk;

  rijn256_enc dut_i (
    .clk(clk), .rstN(rstN), .start(start), .keyIn(keyIn),
    .plainIn(plainIn), .done(done), .cipherOut(cipherOut)
  );

  // key in the upper half, plaintext in the lower half
  localparam logic [511:0] VECS [5] = '{
    {256'h0, 256'h0},
    {{8{32'hffffffff}}, {8{32'hffffffff}}},
    {256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f,
     256'h00112233445566778899aabbccddeeff00112233445566778899aabbccddeeff},
    {{4{64'h0123456789abcdef}}, {8{32'h80000000}}},
    {{8{32'h0000001b}}, {2{128'hdeadbeef_cafef00d_13579bdf_2468ace0}}}
  };

  function automatic logic [7:0] mulTb(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    logic [7:0] aa = a;
    logic [7:0] bb = b;
    for (int i = 0; i < 8; i++) begin
      if (bb[0]) p = p ^ aa;
      aa = aa[7] ? ((aa << 1) ^ 8'h1b) : (aa << 1);
      bb = bb >> 1;
    end
    return p;
  endfunction

  function automatic int shTb(input int r);
    return (r == 0) ? 0 : (r == 1) ? 1 : (r == 2) ? 3 : 4;
  endfunction

  function automatic logic [31:0] subWTb(input logic [31:0] w);
    return {sbTb[w[31:24]], sbTb[w[23:16]], sbTb[w[15:8]], sbTb[w[7:0]]};
  endfunction

  // reference model: full schedule up front, matrix form of the column mix
  function automatic logic [255:0] refEncrypt(input logic [255:0] k, input logic [255:0] p);
    logic [31:0] w [120];
    logic [7:0]  s [8][4];
    logic [7:0]  t [8][4];
    logic [31:0] tmp;
    logic [7:0]  rc;
    logic [255:0] res;
    for (int i = 0; i < 8; i++) w[i] = k[255-32*i -: 32];
    rc = 8'h01;
    for (int i = 8; i < 120; i++) begin
      tmp = w[i-1];
      if (i % 8 == 0) begin
        tmp = subWTb({tmp[23:0], tmp[31:24]}) ^ {rc, 24'h0};
        rc = mulTb(rc, 8'h02);
      end else if (i % 8 == 4) begin
        tmp = subWTb(tmp);
      end
      w[i] = w[i-8] ^ tmp;
    end
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 4; r++)
        s[c][r] = p[255-8*(4*c+r) -: 8] ^ w[c][31-8*r -: 8];
    for (int rnd = 1; rnd <= 14; rnd++) begin
      for (int c = 0; c < 8; c++)
        for (int r = 0; r < 4; r++)
          t[c][r] = sbTb[s[(c + shTb(r)) % 8][r]];
      for (int c = 0; c < 8; c++)
        for (int r = 0; r < 4; r++)
          if (rnd < 14)
            s[c][r] = mulTb(t[c][r], 8'h02) ^ mulTb(t[c][(r+1)%4], 8'h03) ^
                      t[c][(r+2)%4] ^ t[c][(r+3)%4];
          else
            s[c][r] = t[c][r];
      for (int c = 0; c < 8; c++)
        for (int r = 0; r < 4; r++)
          s[c][r] = s[c][r] ^ w[8*rnd+c][31-8*r -: 8];
    end
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 4; r++)
        res[255-8*(4*c+r) -: 8] = s[c][r];
    return res;
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drives start for one cycle; returns at the first negedge after the accepting edge
  task automatic launch(input logic [255:0] k, input logic [255:0] p);
    @(negedge clk);
    keyIn = k; plainIn = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // counts negedges since the start negedge until done is seen
  task automatic waitDone(input int from, output int lat);
    lat = from;
    while (!done && lat < 60) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    logic [255:0] exp, held, k2, p2;
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv = 8'h00;
      logic [7:0] b;
      for (int y = 1; y < 256; y++) if (mulTb(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      for (int i = 0; i < 8; i++)
        b[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1'b1);
      sbTb[x] = b;
    end

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R1 done after reset", {255'h0, done}, 256'h0);
    check(cipherOut == '0, "R1 cipherOut after reset", cipherOut, 256'h0);

    // table walk: R2 R4 R5 R6 R3
    for (int v = 0; v < 5; v++) begin
      exp = refEncrypt(VECS[v][511:256], VECS[v][255:0]);
      launch(VECS[v][511:256], VECS[v][255:0]);
      waitDone(1, lat);
      check(lat == 16, "R3 latency", 256'(lat), 256'd16);
      check(cipherOut == exp, "R4 R5 R6 R2 ciphertext", cipherOut, exp);
      @(negedge clk);
      check(done == 1'b0, "R3 single-cycle done", {255'h0, done}, 256'h0);
    end

    // random pairs
    for (int v = 0; v < 3; v++) begin
      for (int i = 0; i < 8; i++) begin
        k2[255-32*i -: 32] = $urandom;
        p2[255-32*i -: 32] = $urandom;
      end
      exp = refEncrypt(k2, p2);
      launch(k2, p2);
      waitDone(1, lat);
      check(lat == 16 && cipherOut == exp, "R4 random ciphertext", cipherOut, exp);
    end

    // R7: inputs change after capture
    k2 = VECS[2][511:256]; p2 = VECS[2][255:0];
    exp = refEncrypt(k2, p2);
    launch(k2, p2);
    keyIn = ~k2; plainIn = {8{32'h5a5aa5a5}};
    waitDone(1, lat);
    check(cipherOut == exp, "R7 operands captured at start", cipherOut, exp);

    // R8: start while busy
    exp = refEncrypt(VECS[3][511:256], VECS[3][255:0]);
    launch(VECS[3][511:256], VECS[3][255:0]);
    repeat (3) @(negedge clk);
    keyIn = VECS[4][511:256]; plainIn = VECS[4][255:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone(5, lat);
    check(lat == 16, "R8 latency unaffected by busy start", 256'(lat), 256'd16);
    check(cipherOut == exp, "R8 result of first request", cipherOut, exp);
    held = cipherOut;
    lat = 0;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      if (done) lat++;
    end
    check(lat == 0, "R8 no extra done", 256'(lat), 256'd0);

    // R9: output holds while inputs move without start
    keyIn = '1; plainIn = '0;
    repeat (5) @(negedge clk);
    check(cipherOut == held, "R9 output held", cipherOut, held);

    // R10: back-to-back start in the done cycle
    launch(VECS[1][511:256], VECS[1][255:0]);
    waitDone(1, lat);
    exp = refEncrypt(VECS[0][511:256], VECS[0][255:0]);
    keyIn = VECS[0][511:256]; plainIn = VECS[0][255:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone(1, lat);
    check(lat == 16, "R10 back-to-back latency", 256'(lat), 256'd16);
    check(cipherOut == exp, "R10 back-to-back result", cipherOut, exp);

    // R1: reset mid-run
    launch(VECS[2][511:256], VECS[2][255:0]);
    repeat (4) @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    check(cipherOut == '0, "R1 cipherOut cleared by reset", cipherOut, 256'h0);
    lat = 0;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      if (done) lat++;
    end
    check(lat == 0, "R1 abandoned run gives no done", 256'(lat), 256'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule